// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller-side half of an outbound command ring kept in system memory. Software places 32-bit command words into ring slots and moves a write pointer forward through a small register port. While the run bit is set, the engine walks its own read pointer after the write pointer. For each pending slot it fetches the word through a simple request/acknowledge memory read port and offers it on a valid/ready output toward the link. The word's top four bits name the target codec, and that field is also given on its own output.

The ring depth can be set to 2, 16 or 256 slots. Software owns the write pointer and hardware owns the read pointer. The read pointer can only be zeroed through a two-step handshake: software requests the reset, hardware acknowledges it, and software then clears the acknowledge. A ring is full when one more slot would make the write pointer land on the read pointer. The block refuses a write-pointer value that would overrun unread slots. When the controller is powered down, every register read returns all ones.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, WPTR, RPTR and CTRL read 0x0000 and SIZE reads 0x0002. `ring_empty` is 1, `ring_full` is 0, `ring_level` is 0, and neither `mem_req` nor `cmd_valid` is asserted.
- R2: SIZE is at offset 3, with the code in bits 1:0: code 0 selects 2 slots, code 1 selects 16 and code 2 selects 256. A write of code 3 is ignored. A SIZE write is taken only while the engine is stopped (CTRL bit 1 reads 0). When it is taken, both pointers become zero.
- R3: WPTR is at offset 0, with the pointer in bits 7:0. A written value is reduced modulo the depth. If the reduced value equals the current read pointer, the write is ignored, so unread slots are never given back.
- R4: `ring_empty` is 1 exactly when the pointers are equal. `ring_full` is 1 exactly when (WPTR+1) mod depth equals the read pointer. `ring_level` equals (WPTR − read pointer) mod depth.
- R5: Fetching starts when run is set, the ring is not empty and no read-pointer reset is outstanding. The engine then raises `mem_req` with `mem_addr` = `ring_base` + 4·((read pointer + 1) mod depth), holds it until `mem_ack`, and captures `mem_rdata` on that cycle.
- R6: The captured word is shown on `cmd_data` with `cmd_valid` high, and `cmd_codec` carries bits 31:28 of the word. Both stay stable until `cmd_ready`. On that handshake the read pointer advances by one modulo the depth, so words leave in ring order, one per handshake.
- R7: CTRL is at offset 2. Bit 1 is the run request, and it reads as 1 while either the request or an unfinished fetch/offer is active. Clearing the request lets the word in flight complete, and no further fetch starts.
- R8: RPTR is at offset 1: bits 7:0 give the read pointer and bit 15 is the reset flag. Writing bit 15 = 1 while stopped and with no handshake open zeroes the read pointer at once. Bit 15 then reads 1 after RST_CYCLES cycles. Writing 0 afterwards clears the flag, and RPTR then reads 0x0000. The same request made while the engine is not stopped is ignored.
- R9: From a reset request until software clears the flag, no fetch is issued, even when run is set and the ring holds entries.
- R10: While `pwr_down` is 1, every register read returns 0xFFFF and register writes are ignored.
- R11: An RPTR write with bit 15 = 0 leaves the read pointer unchanged, unless it clears a set flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Controller powered down |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write offset |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 2 | Register read offset |
| reg_rd_data | output | 16 | Register read data (combinational) |
| ring_base | input | ADDR_W | Byte address of slot 0 |
| mem_req | output | 1 | Slot read request |
| mem_addr | output | ADDR_W | Slot byte address |
| mem_ack | input | 1 | Read accepted, data valid |
| mem_rdata | input | 32 | Slot contents |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Link takes the command |
| cmd_data | output | 32 | Command word |
| cmd_codec | output | 4 | Target codec field of the word |
| ring_empty | output | 1 | No pending slots |
| ring_full | output | 1 | One slot short of wrap |
| ring_level | output | 8 | Number of pending slots |

## Verification
The bench goes after the full boundary, where WPTR sits one slot behind the read pointer. A design that accepted the next write there would drop 255 pending commands at once. Wrap-around is exercised at all three depths; an engine that ignored the size mask would fetch past the end of the ring and read the wrong address. The bench clears run while a word is in flight, because an engine that stopped at once would lose that word or misreport its run state. It also sets run while the reset flag is still up, because a read pointer that moved during the handshake would leave software and hardware out of step.

// File: rtl/cre_pkg.sv
package cre_pkg;
   localparam int PTR_W      = 8;
   localparam int REG_W      = 16;
   localparam int CMD_W      = 32;
   localparam int CODEC_W    = 4;
   localparam int RUN_BIT    = 1;
   localparam int RST_BIT    = 15;
   localparam int SLOT_SHIFT = 2;

   typedef logic [PTR_W-1:0] ptr_t;

   typedef enum logic [1:0] {
      RA_WPTR = 2'd0,
      RA_RPTR = 2'd1,
      RA_CTRL = 2'd2,
      RA_SIZE = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      SZ_2    = 2'd0,
      SZ_16   = 2'd1,
      SZ_256  = 2'd2,
      SZ_RSVD = 2'd3
   } size_code_e;

   typedef enum logic [1:0] {
      FE_IDLE  = 2'd0,
      FE_FETCH = 2'd1,
      FE_SEND  = 2'd2
   } fe_state_e;

   typedef enum logic [1:0] {
      RS_OFF  = 2'd0,
      RS_BUSY = 2'd1,
      RS_DONE = 2'd2
   } rs_state_e;

   function automatic ptr_t size_mask(input size_code_e code);
      case (code)
         SZ_2:    return ptr_t'(1);
         SZ_16:   return ptr_t'(15);
         default: return '1;
      endcase
   endfunction
endpackage

// File: rtl/cre_regs.sv
module cre_regs
   import cre_pkg::*;
#(
   parameter int RST_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_down_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic [1:0]       rd_addr_i,
   output logic [REG_W-1:0] rd_data_o,
   input  ptr_t             rp_i,
   input  logic             busy_i,
   output ptr_t             wp_o,
   output ptr_t             mask_o,
   output logic             run_o,
   output logic             rp_clear_o,
   output logic             hold_o
);
   localparam int CNT_W = $clog2(RST_CYCLES + 1);

   ptr_t             wp_q;
   size_code_e       size_q;
   logic             run_q;
   rs_state_e        rs_q;
   logic [CNT_W-1:0] cnt_q;

   logic       wr_ok, stopped;
   logic       wp_acc, size_acc, rst_start, rst_release;
   ptr_t       wp_val;
   size_code_e size_val;
   wire        unused_bits = &{1'b0, wr_data_i[RST_BIT-1:PTR_W]};

   assign mask_o   = size_mask(size_q);
   assign stopped  = !run_q && !busy_i;
   assign wr_ok    = wr_en_i && !pwr_down_i;
   assign wp_val   = wr_data_i[PTR_W-1:0] & mask_o;
   assign size_val = size_code_e'(wr_data_i[1:0]);

   assign wp_acc      = wr_ok && (reg_addr_e'(wr_addr_i) == RA_WPTR) && (wp_val != rp_i);
   assign size_acc    = wr_ok && (reg_addr_e'(wr_addr_i) == RA_SIZE) && stopped
                        && (size_val != SZ_RSVD);
   assign rst_start   = wr_ok && (reg_addr_e'(wr_addr_i) == RA_RPTR) && wr_data_i[RST_BIT]
                        && (rs_q == RS_OFF) && stopped;
   assign rst_release = wr_ok && (reg_addr_e'(wr_addr_i) == RA_RPTR) && !wr_data_i[RST_BIT]
                        && (rs_q == RS_DONE);

   assign rp_clear_o = rst_start || size_acc;
   assign hold_o     = (rs_q != RS_OFF);
   assign wp_o       = wp_q;
   assign run_o      = run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         size_q <= SZ_256;
         run_q  <= 1'b0;
         rs_q   <= RS_OFF;
         cnt_q  <= '0;
      end else begin
         if (size_acc) begin
            size_q <= size_val;
            wp_q   <= '0;
         end else if (wp_acc) begin
            wp_q <= wp_val;
         end
         if (wr_ok && (reg_addr_e'(wr_addr_i) == RA_CTRL))
            run_q <= wr_data_i[RUN_BIT];
         case (rs_q)
            RS_OFF: if (rst_start) begin
               rs_q  <= RS_BUSY;
               cnt_q <= CNT_W'(RST_CYCLES - 1);
            end
            RS_BUSY: if (cnt_q == '0) rs_q <= RS_DONE;
                     else cnt_q <= cnt_q - 1'b1;
            RS_DONE: if (rst_release) rs_q <= RS_OFF;
            default: rs_q <= RS_OFF;
         endcase
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (pwr_down_i) begin
         rd_data_o = '1;
      end else begin
         case (reg_addr_e'(rd_addr_i))
            RA_WPTR: rd_data_o[PTR_W-1:0] = wp_q;
            RA_RPTR: begin
               rd_data_o[PTR_W-1:0] = rp_i;
               rd_data_o[RST_BIT]   = (rs_q == RS_DONE);
            end
            RA_CTRL: rd_data_o[RUN_BIT] = run_q | busy_i;
            default: rd_data_o[1:0] = size_q;
         endcase
      end
   end

   AST_SIZE_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q || busy_i) |=> $stable(size_q)); // R2

   AST_RST_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_q == RS_OFF && (run_q || busy_i)) |=> (rs_q == RS_OFF)); // R8
endmodule

// File: rtl/cre_occ.sv
module cre_occ
   import cre_pkg::*;
(
   input  ptr_t wp_i,
   input  ptr_t rp_i,
   input  ptr_t mask_i,
   output logic empty_o,
   output logic full_o,
   output ptr_t level_o
);
   ptr_t wp_next;

   assign wp_next = (wp_i + 1'b1) & mask_i;
   assign empty_o = (wp_i == rp_i);
   assign full_o  = (wp_next == rp_i);
   assign level_o = (wp_i - rp_i) & mask_i;
endmodule

// File: rtl/cre_fetch.sv
module cre_fetch
   import cre_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               empty_i,
   input  logic               hold_i,
   input  logic               rp_clear_i,
   input  ptr_t               mask_i,
   input  logic [ADDR_W-1:0]  base_i,
   output ptr_t               rp_o,
   output logic               busy_o,
   output logic               mem_req_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   input  logic               mem_ack_i,
   input  logic [CMD_W-1:0]   mem_rdata_i,
   output logic               cmd_valid_o,
   input  logic               cmd_ready_i,
   output logic [CMD_W-1:0]   cmd_data_o,
   output logic [CODEC_W-1:0] cmd_codec_o
);
   fe_state_e        state_q;
   ptr_t             rp_q;
   ptr_t             next_slot;
   logic [CMD_W-1:0] cmd_q;

   assign next_slot   = (rp_q + 1'b1) & mask_i;
   assign mem_addr_o  = base_i + (ADDR_W'(next_slot) << SLOT_SHIFT);
   assign mem_req_o   = (state_q == FE_FETCH);
   assign cmd_valid_o = (state_q == FE_SEND);
   assign cmd_data_o  = cmd_q;
   assign cmd_codec_o = cmd_q[CMD_W-1 -: CODEC_W];
   assign busy_o      = (state_q != FE_IDLE);
   assign rp_o        = rp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FE_IDLE;
         rp_q    <= '0;
         cmd_q   <= '0;
      end else begin
         case (state_q)
            FE_IDLE: if (run_i && !empty_i && !hold_i) state_q <= FE_FETCH;
            FE_FETCH: if (mem_ack_i) begin
               cmd_q   <= mem_rdata_i;
               state_q <= FE_SEND;
            end
            FE_SEND: if (cmd_ready_i) begin
               rp_q    <= next_slot;
               state_q <= FE_IDLE;
            end
            default: state_q <= FE_IDLE;
         endcase
         if (rp_clear_i) rp_q <= '0;
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> mem_req_o); // R5

   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o))); // R6

   AST_RP_ONLY_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rp_clear_i && !(cmd_valid_o && cmd_ready_i)) |=> $stable(rp_q)); // R6

   AST_NO_START_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !busy_o) |=> !busy_o); // R7
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
   import cre_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int RST_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_addr,
   input  logic [15:0]       reg_wr_data,
   input  logic [1:0]        reg_rd_addr,
   output logic [15:0]       reg_rd_data,
   input  logic [ADDR_W-1:0] ring_base,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [31:0]       cmd_data,
   output logic [3:0]        cmd_codec,
   output logic              ring_empty,
   output logic              ring_full,
   output logic [7:0]        ring_level
);
   if (RST_CYCLES < 1 || RST_CYCLES > 999) begin : g_bad_rst
      $error("RST_CYCLES must lie in 1..999");
   end
   if (ADDR_W < PTR_W + SLOT_SHIFT) begin : g_bad_addr
      $error("ADDR_W too narrow for the largest ring");
   end

   ptr_t wp, rp, mask, level;
   logic run, busy, rp_clear, hold, empty_c, full_c;

   cre_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
      .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down),
      .wr_en_i(reg_wr_en), .wr_addr_i(reg_wr_addr), .wr_data_i(reg_wr_data),
      .rd_addr_i(reg_rd_addr), .rd_data_o(reg_rd_data),
      .rp_i(rp), .busy_i(busy), .wp_o(wp), .mask_o(mask), .run_o(run),
      .rp_clear_o(rp_clear), .hold_o(hold)
   );

   cre_occ u_occ (
      .wp_i(wp), .rp_i(rp), .mask_i(mask),
      .empty_o(empty_c), .full_o(full_c), .level_o(level)
   );

   cre_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .run_i(run), .empty_i(empty_c), .hold_i(hold),
      .rp_clear_i(rp_clear), .mask_i(mask), .base_i(ring_base),
      .rp_o(rp), .busy_o(busy),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
      .mem_rdata_i(mem_rdata),
      .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
      .cmd_data_o(cmd_data), .cmd_codec_o(cmd_codec)
   );

   assign ring_empty = empty_c;
   assign ring_full  = full_c;
   assign ring_level = level;

   AST_HOLD_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (!mem_req && !cmd_valid)); // R9

   AST_NOT_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_empty && ring_full)); // R4
endmodule

// File: tb/cmd_ring_engine_tb.sv
module cmd_ring_engine_tb_top;
   localparam int ADDR_W     = 32;
   localparam int RST_CYCLES = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_down = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_wr_addr = '0;
   logic [15:0] reg_wr_data = '0;
   logic [1:0]  reg_rd_addr = '0;
   logic [15:0] reg_rd_data;
   logic [31:0] ring_base = 32'h0010_0000;
   logic        mem_req, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_rdata;
   logic        cmd_valid, cmd_ready = 1'b0;
   logic [31:0] cmd_data;
   logic [3:0]  cmd_codec;
   logic        ring_empty, ring_full;
   logic [7:0]  ring_level;

   always #10 clk = ~clk;

   cmd_ring_engine #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .ring_base(ring_base),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .cmd_codec(cmd_codec), .ring_empty(ring_empty), .ring_full(ring_full),
      .ring_level(ring_level)
   );

   logic [31:0] mem [256];
   logic [31:0] word_off;
   assign word_off  = (mem_addr - ring_base) >> 2;
   assign mem_rdata = mem[word_off[7:0]];

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic cmp_on = 1'b0;
   int ack_mode = 0, rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   // reference model state
   int m_wp, m_rp, m_size, m_run, m_st, m_rs, m_cnt;
   logic [31:0] m_cmd;

   function automatic int mmask(input int c);
      return (c == 0) ? 1 : (c == 1) ? 15 : 255;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin : ref_model
      int mk, stp, v, n_wp, n_rp, n_size, n_run, n_st, n_rs, n_cnt;
      logic [31:0] n_cmd;
      if (!rst_n) begin
         m_wp = 0; m_rp = 0; m_size = 2; m_run = 0; m_st = 0; m_rs = 0; m_cnt = 0; m_cmd = '0;
      end else begin
         mk = mmask(m_size);
         stp = (m_run == 0 && m_st == 0);
         n_wp = m_wp; n_rp = m_rp; n_size = m_size; n_run = m_run; n_st = m_st;
         n_rs = m_rs; n_cnt = m_cnt; n_cmd = m_cmd;
         if (m_rs == 1) begin
            if (m_cnt == 0) n_rs = 2; else n_cnt = m_cnt - 1;
         end
         if (reg_wr_en && !pwr_down) begin
            case (reg_wr_addr)
               2'd0: begin v = int'(reg_wr_data) & mk; if (v != m_rp) n_wp = v; end
               2'd1: if (reg_wr_data[15] && m_rs == 0 && stp) begin
                        n_rs = 1; n_cnt = RST_CYCLES - 1; n_rp = 0;
                     end else if (!reg_wr_data[15] && m_rs == 2) n_rs = 0;
               2'd2: n_run = int'(reg_wr_data[1]);
               default: if (stp && reg_wr_data[1:0] != 2'd3) begin
                        n_size = int'(reg_wr_data[1:0]); n_wp = 0; n_rp = 0;
                     end
            endcase
         end
         case (m_st)
            0: if (m_run != 0 && m_wp != m_rp && m_rs == 0) n_st = 1;
            1: if (mem_ack) begin n_cmd = mem[(m_rp + 1) & mk]; n_st = 2; end
            default: if (cmd_ready) begin n_rp = (m_rp + 1) & mk; n_st = 0; end
         endcase
         m_wp = n_wp; m_rp = n_rp; m_size = n_size; m_run = n_run; m_st = n_st;
         m_rs = n_rs; m_cnt = n_cnt; m_cmd = n_cmd;
      end
   end

   always @(negedge clk) begin : compare
      int mk;
      logic [31:0] exp_rd;
      if (rst_n && cmp_on) begin
         mk = mmask(m_size);
         chk("R4 empty", 32'(ring_empty), 32'(m_wp == m_rp));
         chk("R4 full", 32'(ring_full), 32'(((m_wp + 1) & mk) == m_rp));
         chk("R4 level", 32'(ring_level), 32'((m_wp - m_rp) & mk));
         chk("R5 req", 32'(mem_req), 32'(m_st == 1));
         if (m_st == 1) chk("R5 addr", mem_addr, ring_base + 32'(((m_rp + 1) & mk) * 4));
         chk("R6 valid", 32'(cmd_valid), 32'(m_st == 2));
         if (m_st == 2) begin
            chk("R6 data", cmd_data, m_cmd);
            chk("R6 codec", 32'(cmd_codec), 32'(m_cmd[31:28]));
         end
         case (reg_rd_addr)
            2'd0: exp_rd = 32'(m_wp);
            2'd1: exp_rd = 32'(m_rp) | ((m_rs == 2) ? 32'h8000 : 32'h0);
            2'd2: exp_rd = (m_run != 0 || m_st != 0) ? 32'h2 : 32'h0;
            default: exp_rd = 32'(m_size);
         endcase
         if (pwr_down) chk("R10 pd read", 32'(reg_rd_data), 32'hFFFF);
         else case (reg_rd_addr)
            2'd0: chk("R3 WPTR", 32'(reg_rd_data), exp_rd);
            2'd1: chk("R8/R11 RPTR", 32'(reg_rd_data), exp_rd);
            2'd2: chk("R7 CTRL", 32'(reg_rd_data), exp_rd);
            default: chk("R2 SIZE", 32'(reg_rd_data), exp_rd);
         endcase
      end
      reg_rd_addr = reg_rd_addr + 2'd1;
   end

   always @(posedge clk) begin : handshake_drive
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ack   = (ack_mode == 0) ? 1'b1 : lfsr[0];
      cmd_ready = (rdy_mode == 0) ? 1'b1 : lfsr[5];
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin : watchdog
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL R5 watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(posedge clk); #2;
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(posedge clk); #2;
      reg_wr_en = 1'b0;
   endtask

   task automatic wait_stop();
      while (!(m_st == 0 && m_run == 0)) @(posedge clk);
      repeat (2) @(posedge clk);
   endtask

   task automatic drain();
      while (m_wp != m_rp || m_st != 0) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin : stimulus
      logic [7:0] lvl;
      for (int i = 0; i < 256; i++)
         mem[i] = {4'(i * 7), 4'hA, 8'(i), 16'(i * 977 + 3)};
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      cmp_on = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 empty", 32'(ring_empty), 32'd1);
      chk("R1 full", 32'(ring_full), 32'd0);
      chk("R1 req", 32'(mem_req), 32'd0);
      chk("R1 valid", 32'(cmd_valid), 32'd0);
      repeat (4) @(negedge clk);

      // read-pointer reset handshake, then a plain RPTR write
      wr(2'd3, 16'h0002);
      wr(2'd1, 16'h8000);
      repeat (RST_CYCLES + 2) @(posedge clk);
      wr(2'd1, 16'h0000);
      wr(2'd1, 16'h0005);
      @(negedge clk);
      chk("R11 rp unchanged", 32'(ring_level), 32'd0);

      // basic run with always-ready handshakes
      wr(2'd0, 16'h0005);
      wr(2'd2, 16'h0002);
      drain();
      ack_mode = 1; rdy_mode = 1;
      wr(2'd0, 16'd20);
      drain();

      // full boundary at 256 slots
      wr(2'd2, 16'h0000);
      wait_stop();
      wr(2'd0, 16'd19);
      @(negedge clk);
      chk("R4 full at 255", 32'(ring_full), 32'd1);
      wr(2'd0, 16'd20);
      @(negedge clk);
      chk("R3 overrun ignored", 32'(ring_level), 32'd255);
      wr(2'd2, 16'h0002);
      drain();

      // stop with a word in flight
      wr(2'd0, 16'd60);
      repeat (7) @(posedge clk);
      wr(2'd2, 16'h0000);
      wait_stop();
      @(negedge clk);
      lvl = ring_level;
      repeat (20) @(negedge clk);
      chk("R7 stays stopped", 32'(ring_level), 32'(lvl));
      wr(2'd2, 16'h0002);
      drain();

      // 16-slot ring, wrap and masking
      wr(2'd2, 16'h0000);
      wait_stop();
      wr(2'd3, 16'h0001);
      wr(2'd0, 16'd15);
      @(negedge clk);
      chk("R2 full at 16", 32'(ring_full), 32'd1);
      chk("R2 level at 16", 32'(ring_level), 32'd15);
      wr(2'd3, 16'h0003);
      wr(2'd2, 16'h0002);
      wr(2'd3, 16'h0002);
      drain();
      wr(2'd0, 16'd5);
      drain();
      wr(2'd0, 16'h0013);
      drain();

      // fetch held while the reset flag is up
      wr(2'd2, 16'h0000);
      wait_stop();
      wr(2'd1, 16'h8000);
      wr(2'd2, 16'h0002);
      wr(2'd0, 16'd4);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         chk("R9 no fetch", 32'(mem_req), 32'd0);
      end
      wr(2'd1, 16'h0000);
      drain();

      // power down
      @(posedge clk); #2 pwr_down = 1'b1;
      wr(2'd0, 16'd9);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10 write ignored", 32'(ring_level), 32'd0);
      @(posedge clk); #2 pwr_down = 1'b0;

      // 2-slot ring
      wr(2'd2, 16'h0000);
      wait_stop();
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'd1);
      @(negedge clk);
      chk("R2 full at 2", 32'(ring_full), 32'd1);
      wr(2'd2, 16'h0002);
      drain();
      wr(2'd0, 16'd0);
      drain();

      repeat (5) @(posedge clk);
      summary();
      $finish;
   end
endmodule